// File: doc/BRIEF.md
# Two-Wire Bus Byte Memory Target

This block is a 256-byte memory that answers as a target on a two-wire serial bus (I2C/SMBus signalling). Its 7-bit bus address is a fixed upper part, 0x50 by default, with the low three bits taken from a strap input. Up to eight copies can therefore share one bus. The clock and data lines arrive as plain inputs. The block pulls the data line low through a single open-drain style output. It never drives the line high.

A write transaction carries an offset byte first, which moves the internal 8-bit byte pointer. Every later byte in that transaction is stored at the pointer. A read transaction streams bytes out from the pointer. The pointer advances after every stored or returned byte and rolls over from 255 to 0 across the whole array. Reset reloads the complete array from a 2048-bit image input and clears the pointer. A status output reports whether any data transfer has happened since the last reset.

Top module: `smb_eeprom_target`

## Requirements
- R1: While reset is asserted and right after it, the pointer is 0, the array holds the image (byte k at image bits [8k+7:8k]), `sda_low` is 0 and `touched` is 0.
- R2: The target acknowledges (pulls SDA low during the ninth clock) only the address byte whose upper seven bits equal {4'b1010, dev_sel}. For any other address it keeps SDA released for the whole transaction and ignores its bytes. The pointer and the array stay unchanged.
- R3: The first byte after a write address is loaded into the pointer and is not stored in the array.
- R4: Each further byte of a write is stored at the pointer, and the pointer then rises by one modulo 256, so 255 is followed by 0.
- R5: The target acknowledges every byte written to it, offset byte included.
- R6: A read address bit of 1 starts a read. Each byte returned is the array byte at the pointer, sent MSB first. The pointer then rises by one modulo 256.
- R7: After each read byte the target releases SDA for the master's acknowledge bit. A master acknowledge (SDA low) makes it send the next byte. A master NACK (SDA high) ends the read with SDA released.
- R8: A repeated START (SDA falling while SCL is high) in mid-transaction restarts address matching and leaves the pointer unchanged.
- R9: `touched` goes to 1 when a byte is written or read and stays 1 until the next reset.
- R10: The target changes its SDA drive only while SCL is low, except that a START or STOP releases it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset; reloads the array |
| dev_sel | input | 3 | Low three bits of the bus address |
| init_image | input | 2048 | Reset image, byte k at bits [8k+7:8k] |
| scl_in | input | 1 | Bus clock line as seen on the wire |
| sda_in | input | 1 | Bus data line as seen on the wire |
| sda_low | output | 1 | 1 pulls the data line low |
| touched | output | 1 | Sticky flag: data moved since reset |

## Verification
Two events can land on the same clock edge. One is the store of a byte at offset 255. The other is the pointer rolling over to 0, which happens on that same edge. The bench provokes this by writing runs that start at 0xFE or at a random offset, then reading them back through a repeated START from the same offset. The readback is judged against a bench-side model of the array and pointer.

// File: rtl/smb_eeprom_target.sv
module smb_eeprom_target #(
  parameter logic [3:0] ADDR_HI = 4'b1010,
  parameter int PW = 8,
  parameter int DW = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [2:0]              dev_sel,
  input  logic [(1<<PW)*DW-1:0]   init_image,
  input  logic                    scl_in,
  input  logic                    sda_in,
  output logic                    sda_low,
  output logic                    touched
);
  localparam int DEPTH = 1 << PW;
  localparam int CW = $clog2(DW + 1);

  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_AACK, S_WR, S_WACK, S_RD, S_RACK} state_t;

  state_t           state;
  logic [2:0]       scl_sy, sda_sy;
  logic [CW-1:0]    cnt;
  logic [DW-1:0]    sr;
  logic [DW-2:0]    tx;
  logic [PW-1:0]    ptr;
  logic             rd, first, mack;
  logic [DW-1:0]    mem [DEPTH];

  wire scl_now  = scl_sy[1];
  wire scl_prev = scl_sy[2];
  wire sda_now  = sda_sy[1];
  wire sda_prev = sda_sy[2];
  wire scl_rise = scl_now & ~scl_prev;
  wire scl_fall = ~scl_now & scl_prev;
  wire start_det = scl_now & scl_prev & sda_prev & ~sda_now;
  wire stop_det  = scl_now & scl_prev & ~sda_prev & sda_now;
  wire [6:0] my_addr = {ADDR_HI, dev_sel};
  wire [DW-1:0] rd_byte = mem[ptr];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_sy <= '1;
      sda_sy <= '1;
    end else begin
      scl_sy <= {scl_sy[1:0], scl_in};
      sda_sy <= {sda_sy[1:0], sda_in};
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      state   <= S_IDLE;
      cnt     <= '0;
      sr      <= '0;
      tx      <= '0;
      ptr     <= '0;
      rd      <= 1'b0;
      first   <= 1'b0;
      mack    <= 1'b0;
      sda_low <= 1'b0;
      touched <= 1'b0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= init_image[i*DW +: DW];
    end else if (start_det) begin
      state   <= S_ADDR;
      cnt     <= '0;
      sda_low <= 1'b0;
    end else if (stop_det) begin
      state   <= S_IDLE;
      sda_low <= 1'b0;
    end else begin
      case (state)
        S_ADDR:
          if (scl_rise) begin
            sr  <= {sr[DW-2:0], sda_now};
            cnt <= cnt + 1'b1;
          end else if (scl_fall && cnt == CW'(DW)) begin
            if (sr[DW-1:1] == my_addr) begin
              sda_low <= 1'b1;
              rd      <= sr[0];
              state   <= S_AACK;
            end else begin
              state <= S_IDLE;
            end
          end
        S_AACK:
          if (scl_fall) begin
            cnt <= '0;
            if (rd) begin
              tx      <= rd_byte[DW-2:0];
              sda_low <= ~rd_byte[DW-1];
              ptr     <= ptr + 1'b1;
              touched <= 1'b1;
              state   <= S_RD;
            end else begin
              sda_low <= 1'b0;
              first   <= 1'b1;
              state   <= S_WR;
            end
          end
        S_WR:
          if (scl_rise) begin
            sr  <= {sr[DW-2:0], sda_now};
            cnt <= cnt + 1'b1;
          end else if (scl_fall && cnt == CW'(DW)) begin
            sda_low <= 1'b1;
            touched <= 1'b1;
            if (first) begin
              ptr   <= sr[PW-1:0];
              first <= 1'b0;
            end else begin
              mem[ptr] <= sr;
              ptr      <= ptr + 1'b1;
            end
            state <= S_WACK;
          end
        S_WACK:
          if (scl_fall) begin
            sda_low <= 1'b0;
            cnt     <= '0;
            state   <= S_WR;
          end
        S_RD:
          if (scl_fall) begin
            if (cnt == CW'(DW - 1)) begin
              sda_low <= 1'b0;
              state   <= S_RACK;
            end else begin
              tx      <= {tx[DW-3:0], 1'b0};
              sda_low <= ~tx[DW-2];
              cnt     <= cnt + 1'b1;
            end
          end
        S_RACK:
          if (scl_rise) begin
            mack <= ~sda_now;
          end else if (scl_fall) begin
            cnt <= '0;
            if (mack) begin
              tx      <= rd_byte[DW-2:0];
              sda_low <= ~rd_byte[DW-1];
              ptr     <= ptr + 1'b1;
              state   <= S_RD;
            end else begin
              state <= S_IDLE;
            end
          end
        default: state <= S_IDLE;
      endcase
    end

  assert_addr_phase_released_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_IDLE || state == S_ADDR) |-> !sda_low);

  assert_write_acked_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_WACK) |-> sda_low);

  assert_master_ack_slot_free_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_RACK) |-> !sda_low);

  assert_drive_moves_scl_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ((sda_low != $past(sda_low)) && !$past(start_det || stop_det)) |-> !$past(scl_now));

  assert_touched_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    touched |=> touched);

  assert_ptr_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr != $past(ptr)) |-> ((ptr == PW'($past(ptr) + 1'b1)) || $past(first)));
endmodule

// File: tb/smb_eeprom_target_bench.sv
module smb_eeprom_target_bench;
  localparam int CLK_PERIOD = 10;
  localparam int Q = 6;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [2:0]    dev_sel = 3'd3;
  logic [2047:0] image;
  logic          scl_m = 1'b1;
  logic          sda_m = 1'b1;
  wire           sda_low;
  wire           touched;
  wire           sda_bus = sda_m & ~sda_low;

  int checks = 0;
  int fails = 0;
  logic [7:0] model [256];
  logic [7:0] ptr_m;

  smb_eeprom_target u_smb_eeprom_target (
    .clk(clk), .rst_n(rst_n), .dev_sel(dev_sel), .init_image(image),
    .scl_in(scl_m), .sda_in(sda_bus), .sda_low(sda_low), .touched(touched)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] addr_byte(input logic [2:0] sel, input logic is_rd);
    return {4'b1010, sel, is_rd};
  endfunction

  task automatic bus_start();
    sda_m = 1'b1; tick(Q);
    scl_m = 1'b1; tick(Q);
    sda_m = 1'b0; tick(Q);
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; tick(Q);
    scl_m = 1'b1; tick(Q);
    sda_m = 1'b1; tick(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; tick(Q);
      scl_m = 1'b1; tick(Q);
      scl_m = 1'b0; tick(Q);
    end
    sda_m = 1'b1; tick(Q);
    scl_m = 1'b1; tick(Q);
    ack = ~sda_bus;
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic recv_byte(input logic give_ack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      tick(Q);
      scl_m = 1'b1; tick(Q);
      b[i] = sda_bus;
      scl_m = 1'b0;
    end
    tick(Q);
    sda_m = ~give_ack; tick(Q);
    scl_m = 1'b1; tick(Q);
    scl_m = 1'b0; tick(Q);
    sda_m = 1'b1;
  endtask

  task automatic write_run(input logic [7:0] off, input int n, input logic do_stop);
    logic ack;
    logic [7:0] b;
    bus_start();
    send_byte(addr_byte(dev_sel, 1'b0), ack);
    chk("R2 own write address acked", ack, 1'b1);
    send_byte(off, ack);
    chk("R5 offset byte acked", ack, 1'b1);
    ptr_m = off;
    for (int i = 0; i < n; i++) begin
      b = 8'($urandom);
      send_byte(b, ack);
      chk("R5 data byte acked", ack, 1'b1);
      model[ptr_m] = b;
      ptr_m = ptr_m + 8'd1;
    end
    if (do_stop) bus_stop();
  endtask

  task automatic read_run(input int n, input string tag);
    logic ack;
    logic [7:0] b;
    bus_start();
    send_byte(addr_byte(dev_sel, 1'b1), ack);
    chk("R2 own read address acked", ack, 1'b1);
    for (int i = 0; i < n; i++) begin
      recv_byte(i < n - 1, b);
      chk(tag, b, model[ptr_m]);
      ptr_m = ptr_m + 8'd1;
    end
    chk("R7 SDA released after master NACK", sda_low, 1'b0);
    bus_stop();
  endtask

  task automatic read_from(input logic [7:0] off, input int n, input string tag);
    write_run(off, 0, 1'b0);
    read_run(n, tag);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    tick(3);
    chk("R1 sda released in reset", sda_low, 1'b0);
    rst_n = 1'b1;
    tick(2);
    for (int i = 0; i < 256; i++) model[i] = image[i*8 +: 8];
    ptr_m = 8'd0;
  endtask

  initial begin
    tick(190000);
    fails++;
    $display("FAIL watchdog expired (all R) actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic ack;
    void'($urandom(32'h5EED1234));
    for (int i = 0; i < 64; i++) image[i*32 +: 32] = $urandom;
    do_reset();
    chk("R1 touched clear after reset", touched, 1'b0);
    chk("R1 sda released after reset", sda_low, 1'b0);

    bus_start();
    send_byte(addr_byte(3'd0, 1'b0), ack);
    chk("R2 foreign address not acked", ack, 1'b0);
    send_byte(8'h77, ack);
    chk("R2 foreign data not acked", ack, 1'b0);
    bus_stop();
    chk("R9 touched stays clear on foreign traffic", touched, 1'b0);

    read_run(3, "R1 R6 reset image at pointer 0");
    chk("R9 touched set by read", touched, 1'b1);

    write_run(8'hFE, 4, 1'b1);
    read_from(8'hFD, 6, "R4 R6 R8 wrap across 255 to 0");

    write_run(8'h10, 0, 1'b1);
    read_run(2, "R3 offset byte not stored");

    for (int t = 0; t < 14; t++) begin
      logic [7:0] off;
      int n;
      off = 8'($urandom);
      n = 1 + int'($urandom % 5);
      write_run(off, n, 1'b0);
      read_from(off, n + 1, "R4 R6 R8 random run readback");
    end
    chk("R9 touched still set", touched, 1'b1);

    do_reset();
    chk("R1 touched cleared by reset", touched, 1'b0);
    read_run(2, "R1 pointer cleared by reset");
    read_from(8'hFE, 4, "R1 image restored at FE..01");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule